// File: doc/BRIEF.md
# Double-Precision to Signed Integer Converter

This block turns one IEEE-754 binary64 value into a two's-complement integer. The integer is 32 bits wide by default, or 64 bits wide when the wide select is high. A 2-bit rounding control picks how a value with a fractional part is brought to an integer. The block raises a precision flag when the value it returns differs from the exact input.

Values that cannot be represented give the integer indefinite pattern and raise the invalid flag. These are NaN, either infinity, and anything whose rounded magnitude falls outside the selected width. The indefinite pattern has the top bit of the selected width set and every other bit clear. If the invalid condition is unmasked, a separate fault output is also raised, so the surrounding pipeline can cancel the register write.

The datapath is registered once. A request presented with `inValid` appears on the outputs on the next clock edge, together with `outValid`.

Top module: `dbl2int_cvt`

## Requirements
- R1: A request sampled with `inValid` high at a rising edge produces `outValid` high after that edge. `outValid` is low after any edge where `inValid` was low. Between requests, `result` and the flags keep their last captured values.
- R2: A double whose value is an exact integer in range converts to that integer, with the invalid and precision flags low.
- R3: Inexact values are rounded by `rndMode`. The encoding is 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R4: `precisionFlag` is high exactly when the input had a nonzero fractional part and the conversion is valid.
- R5: If the rounded value exceeds the selected width's range, `invalidFlag` is raised and `result` is the indefinite value. The indefinite value is 0x0000_0000_8000_0000 in narrow mode and 0x8000_0000_0000_0000 in wide mode. The exact minimum integer of each width converts with no invalid.
- R6: An input with all exponent bits set (bits 62:52 all ones), meaning NaN or infinity, raises `invalidFlag` and returns the indefinite value.
- R7: `precisionFlag` is never high together with `invalidFlag`, even when the out-of-range input had a fractional part.
- R8: Positive or negative zero gives 0 with no flags. A subnormal input gives 0, or +1 / -1 where the rounding direction requires it, and always raises `precisionFlag`.
- R9: With `wideSel` low, `result[63:32]` is zero, and a negative result shows as its 32-bit two's-complement pattern in `result[31:0]`.
- R10: `fault` equals `invalidFlag` AND NOT the captured `invMask`. `result` is the indefinite value whenever invalid is raised, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe for the current inputs |
| operand | input | 64 | binary64 source value |
| rndMode | input | 2 | Rounding control (00 nearest-even, 01 down, 10 up, 11 toward zero) |
| invMask | input | 1 | High when the invalid condition is masked |
| wideSel | input | 1 | High selects a 64-bit result, low a 32-bit one |
| outValid | output | 1 | Outputs hold a fresh conversion |
| result | output | 64 | Converted integer or indefinite value |
| invalidFlag | output | 1 | Invalid condition detected |
| precisionFlag | output | 1 | Result is inexact |
| fault | output | 1 | Invalid with the mask clear; the write should be suppressed |

## Verification
The hardest case to reach is the edge of the range, where the rounding step alone decides between a valid result and an invalid one. The same input value has to land on both sides of that edge. For that, the stimulus drives 2147483647.5 in narrow mode twice. Toward zero it must give 0x7FFFFFFF with precision set. Nearest-even must carry it to 2^31 and return the indefinite value with precision cleared. The stimulus also drives -2^31 and -2^63, which have the same bit pattern as the indefinite value, and checks that the flags alone tell them apart.

// File: rtl/d2i_pkg.sv
package d2i_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_DOWN    = 2'b01,
    RND_UP      = 2'b10,
    RND_ZERO    = 2'b11
  } rndMode_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic capture;
  } d2iStrobe_t;

endpackage

// File: rtl/d2i_align.sv
// Splits a binary64 magnitude into integer part, round bit and sticky bit.
module d2i_align #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64
) (
  input  logic [EXP_W-1:0]  expField,
  input  logic [FRAC_W-1:0] fracField,
  output logic [INT_W-1:0]  magInt,
  output logic              roundBit,
  output logic              stickyBit,
  output logic              special,
  output logic              overRange
);
  localparam int MAN_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXT_W  = 2 * MAN_W + 2;
  localparam int MAX_RS = MAN_W + 1;

  logic [MAN_W-1:0] mantissa;
  logic [EXT_W-1:0] extWord;
  int expUnb;
  int rightShift;
  int leftShift;

  assign special  = &expField;
  assign mantissa = {(expField != '0), fracField};

  always_comb begin
    // subnormals share the scale of the smallest normal exponent
    expUnb     = (expField == '0) ? (1 - BIAS) : (int'(expField) - BIAS);
    overRange  = (expUnb > INT_W - 1);
    magInt     = '0;
    roundBit   = 1'b0;
    stickyBit  = 1'b0;
    extWord    = '0;
    rightShift = 0;
    leftShift  = 0;
    if (expUnb >= FRAC_W) begin
      leftShift = expUnb - FRAC_W;
      if (leftShift > INT_W - MAN_W) leftShift = INT_W - MAN_W;
      magInt = {{(INT_W-MAN_W){1'b0}}, mantissa} << leftShift;
    end else begin
      rightShift = FRAC_W - expUnb;
      if (rightShift > MAX_RS) rightShift = MAX_RS;
      extWord   = {mantissa, {(MAN_W+1){1'b0}}} >> rightShift;
      magInt    = {{(INT_W-MAN_W){1'b0}}, extWord[EXT_W-1:MAN_W+1]};
      roundBit  = extWord[MAN_W];
      stickyBit = |extWord[MAN_W-1:0];
    end
  end
endmodule

// File: rtl/d2i_round.sv
// Applies the rounding direction to an aligned magnitude.
module d2i_round
  import d2i_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  logic [INT_W-1:0] magInt,
  input  logic             roundBit,
  input  logic             stickyBit,
  input  logic             signBit,
  input  logic [1:0]       rndMode,
  output logic [INT_W:0]   magRounded,
  output logic             inexact
);
  logic bumpUp;
  rndMode_e modeSel;

  assign modeSel = rndMode_e'(rndMode);
  assign inexact = roundBit | stickyBit;

  always_comb begin
    unique case (modeSel)
      RND_NEAREST: bumpUp = roundBit & (stickyBit | magInt[0]);
      RND_DOWN:    bumpUp = signBit & inexact;
      RND_UP:      bumpUp = ~signBit & inexact;
      default:     bumpUp = 1'b0;
    endcase
  end

  assign magRounded = {1'b0, magInt} + {{INT_W{1'b0}}, bumpUp};
endmodule

// File: rtl/d2i_ctrl.sv
// Valid tracking and capture strobe generation.
module d2i_ctrl
  import d2i_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output d2iStrobe_t stb,
  output logic       outValid
);
  assign stb.capture = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/d2i_dpath.sv
// Conversion datapath with range check and output register.
module d2i_dpath
  import d2i_pkg::*;
#(
  parameter int DBL_W    = 64,
  parameter int EXP_W    = 11,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  d2iStrobe_t       stb,
  input  logic [DBL_W-1:0] operand,
  input  logic [1:0]       rndMode,
  input  logic             invMask,
  input  logic             wideSel,
  output logic [INT_W-1:0] result,
  output logic             invalidFlag,
  output logic             precisionFlag,
  output logic             fault
);
  localparam int FRAC_W = DBL_W - EXP_W - 1;
  localparam int UPPER_W = INT_W - NARROW_W;

  localparam logic [INT_W:0] POS_LIM_WIDE = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] POS_LIM_NARROW = {{(UPPER_W+2){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic [INT_W-1:0] INDEF_WIDE = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] INDEF_NARROW = {{UPPER_W{1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

  logic             signBit;
  logic [INT_W-1:0] magInt;
  logic             roundBit, stickyBit, special, overRange;
  logic [INT_W:0]   magRounded;
  logic             inexact;
  logic [INT_W:0]   posLim, negLim;
  logic             badRange, invalidNext;
  logic [INT_W-1:0] signedVal, resultNext;

  assign signBit = operand[DBL_W-1];

  d2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) align_i (
    .expField  (operand[DBL_W-2:FRAC_W]),
    .fracField (operand[FRAC_W-1:0]),
    .magInt    (magInt),
    .roundBit  (roundBit),
    .stickyBit (stickyBit),
    .special   (special),
    .overRange (overRange)
  );

  d2i_round #(.INT_W(INT_W)) round_i (
    .magInt     (magInt),
    .roundBit   (roundBit),
    .stickyBit  (stickyBit),
    .signBit    (signBit),
    .rndMode    (rndMode),
    .magRounded (magRounded),
    .inexact    (inexact)
  );

  always_comb begin
    posLim      = wideSel ? POS_LIM_WIDE : POS_LIM_NARROW;
    negLim      = posLim + {{INT_W{1'b0}}, 1'b1};
    badRange    = signBit ? (magRounded > negLim) : (magRounded > posLim);
    invalidNext = special | overRange | badRange;
    signedVal   = signBit ? (~magRounded[INT_W-1:0] + 1'b1) : magRounded[INT_W-1:0];
    if (invalidNext)  resultNext = wideSel ? INDEF_WIDE : INDEF_NARROW;
    else if (wideSel) resultNext = signedVal;
    else              resultNext = {{UPPER_W{1'b0}}, signedVal[NARROW_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result        <= '0;
      invalidFlag   <= 1'b0;
      precisionFlag <= 1'b0;
      fault         <= 1'b0;
    end else if (stb.capture) begin
      result        <= resultNext;
      invalidFlag   <= invalidNext;
      precisionFlag <= inexact & ~invalidNext;
      fault         <= invalidNext & ~invMask;
    end
  end
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
  import d2i_pkg::*;
#(
  parameter int DBL_W    = 64,
  parameter int EXP_W    = 11,
  parameter int INT_W    = 64,
  parameter int NARROW_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [DBL_W-1:0] operand,
  input  logic [1:0]       rndMode,
  input  logic             invMask,
  input  logic             wideSel,
  output logic             outValid,
  output logic [INT_W-1:0] result,
  output logic             invalidFlag,
  output logic             precisionFlag,
  output logic             fault
);
  d2iStrobe_t stb;

  d2i_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  d2i_dpath #(.DBL_W(DBL_W), .EXP_W(EXP_W), .INT_W(INT_W), .NARROW_W(NARROW_W)) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .operand       (operand),
    .rndMode       (rndMode),
    .invMask       (invMask),
    .wideSel       (wideSel),
    .result        (result),
    .invalidFlag   (invalidFlag),
    .precisionFlag (precisionFlag),
    .fault         (fault)
  );
endmodule

// File: rtl/d2i_checker.sv
module d2i_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [10:0] opExp,
  input logic        invMask,
  input logic        wideSel,
  input logic        outValid,
  input logic [63:0] result,
  input logic        invalidFlag,
  input logic        precisionFlag,
  input logic        fault
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R1
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result) && $stable(invalidFlag) && $stable(precisionFlag)); // R1
  AST_NO_PREC_WITH_INV: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(invalidFlag && precisionFlag)); // R7
  AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (&opExp) |=> invalidFlag); // R6
  AST_INDEF_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    inValid && wideSel |=> !invalidFlag || result == 64'h8000_0000_0000_0000); // R5
  AST_INDEF_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !wideSel |=> !invalidFlag || result == 64'h0000_0000_8000_0000); // R5
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !wideSel |=> result[63:32] == 32'h0); // R9
  AST_FAULT_RULE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> fault == (invalidFlag && !$past(invMask))); // R10
endmodule

bind dbl2int_cvt d2i_checker chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .inValid       (inValid),
  .opExp         (operand[62:52]),
  .invMask       (invMask),
  .wideSel       (wideSel),
  .outValid      (outValid),
  .result        (result),
  .invalidFlag   (invalidFlag),
  .precisionFlag (precisionFlag),
  .fault         (fault)
);

// File: tb/dbl2int_cvt_tb.sv
module dbl2int_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  rndMode = 2'b00;
  logic        invMask = 1'b1;
  logic        wideSel = 1'b0;
  logic        outValid;
  logic [63:0] result;
  logic        invalidFlag, precisionFlag, fault;

  int testsRun = 0;
  int testsFailed = 0;

  localparam logic [1:0] NEAR = 2'b00, DOWN = 2'b01, UP = 2'b10, ZERO = 2'b11;
  localparam logic [63:0] IND32 = 64'h0000_0000_8000_0000;
  localparam logic [63:0] IND64 = 64'h8000_0000_0000_0000;

  always #5 clk = ~clk;

  dbl2int_cvt dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .rndMode(rndMode), .invMask(invMask), .wideSel(wideSel),
    .outValid(outValid), .result(result), .invalidFlag(invalidFlag),
    .precisionFlag(precisionFlag), .fault(fault)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // drive one request, sample one edge later away from the edge
  task automatic convert(input string tag, input logic [63:0] op, input logic [1:0] rm,
                         input logic wide, input logic mask, input logic [63:0] expRes,
                         input logic expInv, input logic expPrec, input logic expFault);
    @(negedge clk);
    operand = op; rndMode = rm; wideSel = wide; invMask = mask; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, "outValid", {63'b0, outValid}, 64'd1);
    check(tag, "result", result, expRes);
    check(tag, "invalid", {63'b0, invalidFlag}, {63'b0, expInv});
    check(tag, "precision", {63'b0, precisionFlag}, {63'b0, expPrec});
    check(tag, "fault", {63'b0, fault}, {63'b0, expFault});
  endtask

  task automatic testReset();
    check("R1", "reset outValid", {63'b0, outValid}, 64'd0);
    check("R1", "reset result", result, 64'd0);
    check("R1", "reset flags", {61'b0, invalidFlag, precisionFlag, fault}, 64'd0);
  endtask

  task automatic testExact();
    convert("R2", 64'h3FF0_0000_0000_0000, NEAR, 1'b0, 1'b1, 64'd1, 0, 0, 0);
    convert("R2", 64'h41DF_FFFF_FFC0_0000, NEAR, 1'b0, 1'b1, 64'h7FFF_FFFF, 0, 0, 0);
    convert("R2", 64'h4330_0000_0000_0001, ZERO, 1'b1, 1'b1, 64'h0010_0000_0000_0001, 0, 0, 0);
  endtask

  task automatic testRounding();
    convert("R3", 64'h4004_0000_0000_0000, NEAR, 1'b0, 1'b1, 64'd2, 0, 1, 0); // 2.5 -> 2
    convert("R3", 64'h400C_0000_0000_0000, NEAR, 1'b0, 1'b1, 64'd4, 0, 1, 0); // 3.5 -> 4
    convert("R3", 64'h3FF8_0000_0000_0000, UP, 1'b0, 1'b1, 64'd2, 0, 1, 0);
    convert("R3", 64'h3FF8_0000_0000_0000, DOWN, 1'b0, 1'b1, 64'd1, 0, 1, 0);
    convert("R3", 64'hC004_0000_0000_0000, DOWN, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFD, 0, 1, 0);
    convert("R3", 64'hC004_0000_0000_0000, UP, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFE, 0, 1, 0);
    convert("R3", 64'hC004_0000_0000_0000, ZERO, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFE, 0, 1, 0);
    convert("R4", 64'hBFF8_0000_0000_0000, NEAR, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1, 0);
    convert("R4", 64'h3FE0_0000_0000_0000, NEAR, 1'b0, 1'b1, 64'd0, 0, 1, 0); // 0.5 -> 0
  endtask

  task automatic testRange();
    convert("R5", 64'h41DF_FFFF_FFE0_0000, ZERO, 1'b0, 1'b1, 64'h7FFF_FFFF, 0, 1, 0);
    convert("R7", 64'h41DF_FFFF_FFE0_0000, NEAR, 1'b0, 1'b1, IND32, 1, 0, 0);
    convert("R5", 64'h41E0_0000_0000_0000, ZERO, 1'b0, 1'b1, IND32, 1, 0, 0);
    convert("R5", 64'hC1E0_0000_0000_0000, ZERO, 1'b0, 1'b1, IND32, 0, 0, 0);
    convert("R5", 64'h43E0_0000_0000_0000, ZERO, 1'b1, 1'b1, IND64, 1, 0, 0);
    convert("R5", 64'hC3E0_0000_0000_0000, ZERO, 1'b1, 1'b1, IND64, 0, 0, 0);
    convert("R5", 64'h41E0_0000_0000_0000, ZERO, 1'b1, 1'b1, 64'h8000_0000, 0, 0, 0);
  endtask

  task automatic testSpecial();
    convert("R6", 64'h7FF8_0000_0000_0000, NEAR, 1'b0, 1'b1, IND32, 1, 0, 0);
    convert("R6", 64'hFFF0_0000_0000_0000, NEAR, 1'b1, 1'b1, IND64, 1, 0, 0);
    convert("R8", 64'h8000_0000_0000_0000, DOWN, 1'b0, 1'b1, 64'd0, 0, 0, 0);
    convert("R8", 64'h0000_0000_0000_0001, NEAR, 1'b0, 1'b1, 64'd0, 0, 1, 0);
    convert("R8", 64'h0000_0000_0000_0001, UP, 1'b1, 1'b1, 64'd1, 0, 1, 0);
    convert("R9", 64'h8000_0000_0000_0001, DOWN, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF, 0, 1, 0);
  endtask

  task automatic testFault();
    convert("R10", 64'h41E0_0000_0000_0000, NEAR, 1'b0, 1'b0, IND32, 1, 0, 1);
    convert("R10", 64'h7FF0_0000_0000_0000, NEAR, 1'b1, 1'b0, IND64, 1, 0, 1);
    convert("R10", 64'h3FF0_0000_0000_0000, NEAR, 1'b0, 1'b0, 64'd1, 0, 0, 0);
  endtask

  task automatic testHold();
    convert("R1", 64'h4004_0000_0000_0000, UP, 1'b0, 1'b1, 64'd3, 0, 1, 0);
    operand = 64'h7FF8_0000_0000_0000;
    @(negedge clk);
    @(negedge clk);
    check("R1", "idle outValid", {63'b0, outValid}, 64'd0);
    check("R1", "idle result held", result, 64'd3);
    check("R1", "idle flags held", {62'b0, invalidFlag, precisionFlag}, 64'd1);
  endtask

  initial begin
    #2_000_000;
    testsFailed++;
    $display("FAIL R1 watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testExact();
    testRounding();
    testRange();
    testSpecial();
    testFault();
    testHold();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule